// File: doc/BRIEF.md
# Register Access Workaround Sequencer

This block sits between a requester that issues single 64-bit register reads and writes and a memory-mapped register bus that carries one access at a time. On silicon revisions that can hang when certain internal registers are touched without preparation, it wraps each qualifying access in dummy reads. These reads go to fixed registers chosen from the target's offset relative to a programmable base. On any other revision, and for targets far enough from the base, the request passes through as a single bus access.

The requester hands over one command with a valid/ready handshake. Ready stays low until every bus access of the sequence has completed. A read returns its data with a one-cycle response strobe once the sequence ends. Data returned by the dummy reads is discarded. The bus side holds address, direction and write data steady until the bus reports completion.

Top module: `reg_guard_sequencer`

## Requirements
- R1: After synchronous reset the block is idle: `req_ready` is 1, `bus_valid` is 0 and `rsp_valid` is 0.
- R2: With `rev_affected` at 0, an accepted command produces exactly one bus access to `req_addr`, with the requested direction and write data.
- R3: With `rev_affected` at 1, a target offset (`req_addr - base_addr`, unsigned and modulo 2^ADDR_W) of 0x45000 or more produces only the single real access. This includes an address below the base.
- R4: With wrapping active, offsets 0x0 and 0x80 are preceded by a dummy read of `base_addr + 0xC0`.
- R5: With wrapping active, offsets 0x148 and 0x200 are preceded by a dummy read of `base_addr + 0x28`.
- R6: With wrapping active, every other offset below 0x45000 is preceded by a dummy read of `base_addr + 0x158`.
- R7: With wrapping active, offset 0x100 is followed by a dummy read of `base_addr + 0x38` and then the final dummy read.
- R8: With wrapping active, the last access of every sequence is a dummy read of `base_addr + 0xB050`. The order is always pre-read, then the real access, then the post-reads.
- R9: Every dummy access is a read (`bus_write` = 0). Only the real access of a write command drives `bus_write` = 1.
- R10: `req_ready` is 0 from the cycle after acceptance until the last access of the sequence completes. While `bus_valid` is 1 and `bus_done` is 0, address, direction and write data stay stable.
- R11: A read command raises `rsp_valid` for exactly one cycle after its sequence ends, with `rsp_rdata` equal to the data of the real access. A write command raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rev_affected | input | 1 | Selects the revision that needs the dummy-read wrapping |
| base_addr | input | ADDR_W | Base address of the register window; offsets are measured from it |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Command accepted when high together with `req_valid` |
| req_addr | input | ADDR_W | Target register address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle strobe carrying read data |
| rsp_rdata | output | DATA_W | Data of the real read |
| bus_valid | output | 1 | Bus access in progress |
| bus_addr | output | ADDR_W | Bus access address |
| bus_write | output | 1 | Bus access direction |
| bus_wdata | output | DATA_W | Bus write data |
| bus_done | input | 1 | Bus completes the current access in this cycle |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_done` |

## Verification
The assertions check on every cycle that reset leaves the block idle and that a pending bus access holds steady until completion. They also check that ready never overlaps bus activity, that the response strobe lasts one cycle, and what the first bus access after acceptance is for the pass-through and offset-zero cases. Only the bench's scenarios can show the full ordered access list for each offset class: the boundary at 0x45000, the extra post-read for offset 0x100, and addresses below the base. They likewise show that the returned data comes from the real access and not from a dummy read, under varying bus latency.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

    localparam int unsigned RGS_ADDR_W = 40;
    localparam int unsigned RGS_DATA_W = 64;

    // Offsets that steer the wrapping; the sequencer depends on every value.
    localparam logic [31:0] GUARD_LIMIT   = 32'h0004_5000;
    localparam logic [31:0] OFF_CFG_LO    = 32'h0000_0000;
    localparam logic [31:0] OFF_CFG_HI    = 32'h0000_0080;
    localparam logic [31:0] OFF_MAP_LO    = 32'h0000_0148;
    localparam logic [31:0] OFF_MAP_HI    = 32'h0000_0200;
    localparam logic [31:0] OFF_TAIL_XTRA = 32'h0000_0100;
    localparam logic [31:0] DUMMY_CFG     = 32'h0000_00C0;
    localparam logic [31:0] DUMMY_MAP     = 32'h0000_0028;
    localparam logic [31:0] DUMMY_OTHER   = 32'h0000_0158;
    localparam logic [31:0] DUMMY_XTRA    = 32'h0000_0038;
    localparam logic [31:0] DUMMY_FINAL   = 32'h0000_B050;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_PRE,
        STEP_REAL,
        STEP_POST_MID,
        STEP_POST_END
    } step_e;

    typedef struct packed {
        logic wrap;
        logic mid;
        logic write;
    } plan_t;

    function automatic step_e step_after(step_e s, plan_t p);
        step_e n;
        case (s)
            STEP_PRE:      n = STEP_REAL;
            STEP_REAL:     n = p.wrap ? (p.mid ? STEP_POST_MID : STEP_POST_END) : STEP_IDLE;
            STEP_POST_MID: n = STEP_POST_END;
            default:       n = STEP_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rgs_planner.sv
module rgs_planner
    import rgs_pkg::*;
#(
    parameter int unsigned ADDR_W = RGS_ADDR_W
) (
    input  logic              affected,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] target,
    output logic              wrap,
    output logic              mid,
    output logic [ADDR_W-1:0] pre_addr,
    output logic [ADDR_W-1:0] mid_addr,
    output logic [ADDR_W-1:0] end_addr
);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] pre_off;

    always_comb begin
        offset = target - base;
        wrap   = affected && (offset < ADDR_W'(GUARD_LIMIT));
        mid    = (offset == ADDR_W'(OFF_TAIL_XTRA));
        if (offset == ADDR_W'(OFF_CFG_LO) || offset == ADDR_W'(OFF_CFG_HI))
            pre_off = ADDR_W'(DUMMY_CFG);
        else if (offset == ADDR_W'(OFF_MAP_LO) || offset == ADDR_W'(OFF_MAP_HI))
            pre_off = ADDR_W'(DUMMY_MAP);
        else
            pre_off = ADDR_W'(DUMMY_OTHER);
        pre_addr = base + pre_off;
        mid_addr = base + ADDR_W'(DUMMY_XTRA);
        end_addr = base + ADDR_W'(DUMMY_FINAL);
    end

endmodule

// File: rtl/rgs_sequencer.sv
module rgs_sequencer
    import rgs_pkg::*;
#(
    parameter int unsigned ADDR_W = RGS_ADDR_W,
    parameter int unsigned DATA_W = RGS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              pl_wrap,
    input  logic              pl_mid,
    input  logic [ADDR_W-1:0] pl_pre,
    input  logic [ADDR_W-1:0] pl_midaddr,
    input  logic [ADDR_W-1:0] pl_end,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata
);

    step_e             step_q;
    step_e             step_nx;
    plan_t             plan_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pre_q;
    logic [ADDR_W-1:0] mid_q;
    logic [ADDR_W-1:0] end_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    assign step_nx = step_after(step_q, plan_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= STEP_IDLE;
            plan_q  <= '0;
            addr_q  <= '0;
            pre_q   <= '0;
            mid_q   <= '0;
            end_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            if (step_q == STEP_IDLE) begin
                if (cmd_valid) begin
                    plan_q  <= '{wrap: pl_wrap, mid: pl_mid, write: cmd_write};
                    addr_q  <= cmd_addr;
                    wdata_q <= cmd_wdata;
                    pre_q   <= pl_pre;
                    mid_q   <= pl_midaddr;
                    end_q   <= pl_end;
                    step_q  <= pl_wrap ? STEP_PRE : STEP_REAL;
                end
            end else if (bus_done) begin
                if (step_q == STEP_REAL && !plan_q.write)
                    rdata_q <= bus_rdata;
                if (step_nx == STEP_IDLE && !plan_q.write)
                    rsp_q <= 1'b1;
                step_q <= step_nx;
            end
        end
    end

    always_comb begin
        case (step_q)
            STEP_PRE:      bus_addr = pre_q;
            STEP_REAL:     bus_addr = addr_q;
            STEP_POST_MID: bus_addr = mid_q;
            STEP_POST_END: bus_addr = end_q;
            default:       bus_addr = '0;
        endcase
    end

    assign cmd_ready = (step_q == STEP_IDLE);
    assign bus_valid = (step_q != STEP_IDLE);
    assign bus_write = (step_q == STEP_REAL) && plan_q.write;
    assign bus_wdata = bus_write ? wdata_q : '0;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/reg_guard_sequencer.sv
module reg_guard_sequencer
    import rgs_pkg::*;
#(
    parameter int unsigned ADDR_W = RGS_ADDR_W,
    parameter int unsigned DATA_W = RGS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rev_affected,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              p_wrap;
    logic              p_mid;
    logic [ADDR_W-1:0] p_pre;
    logic [ADDR_W-1:0] p_midaddr;
    logic [ADDR_W-1:0] p_end;

    rgs_planner #(.ADDR_W(ADDR_W)) u_plan (
        .affected (rev_affected),
        .base     (base_addr),
        .target   (req_addr),
        .wrap     (p_wrap),
        .mid      (p_mid),
        .pre_addr (p_pre),
        .mid_addr (p_midaddr),
        .end_addr (p_end)
    );

    rgs_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (req_valid),
        .cmd_ready  (req_ready),
        .cmd_addr   (req_addr),
        .cmd_write  (req_write),
        .cmd_wdata  (req_wdata),
        .pl_wrap    (p_wrap),
        .pl_mid     (p_mid),
        .pl_pre     (p_pre),
        .pl_midaddr (p_midaddr),
        .pl_end     (p_end),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .bus_wdata  (bus_wdata),
        .bus_done   (bus_done),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: rtl/rgs_checker.sv
module rgs_checker #(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              rev_affected,
    input logic [ADDR_W-1:0] base_addr,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_done,
    input logic [DATA_W-1:0] bus_rdata
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !bus_valid && !rsp_valid));

    p_plain_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rev_affected)
        |=> (bus_valid && bus_addr == $past(req_addr) && bus_write == $past(req_write)));

    p_pre_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && rev_affected && req_addr == base_addr)
        |=> (bus_valid && !bus_write && bus_addr == $past(base_addr) + ADDR_W'(32'hC0)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_done)
        |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_valid);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_rsp_at_idle_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (req_ready && !bus_valid));

endmodule

bind reg_guard_sequencer rgs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rgs_chk (.*);

// File: tb/test_reg_guard_sequencer.sv
`timescale 1ns/1ps
module test_reg_guard_sequencer;

    localparam int AW = 40;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rev_affected = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          bus_valid;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [DW-1:0] bus_wdata;
    logic          bus_done = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [AW-1:0] log_a [8];
    logic          log_w [8];
    logic [DW-1:0] log_d [8];
    int            log_n = 0;
    logic [AW-1:0] exp_a [4];
    logic          exp_w [4];
    logic [DW-1:0] exp_d [4];
    int            exp_n = 0;
    int            rsp_n = 0;
    logic [DW-1:0] rsp_seen = '0;
    int            lat = 0;

    always #4 clk = ~clk;

    reg_guard_sequencer #(.ADDR_W(AW), .DATA_W(DW)) i_reg_guard_sequencer (.*);

    function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
        return {24'h5A_C3_E1, a} ^ 64'h0000_0F0F_0000_3C3C;
    endfunction

    task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    // bus model: random latency, logs each completed access
    initial begin
        forever begin
            @(negedge clk);
            if (bus_done) begin
                bus_done = 1'b0;
                lat = $urandom_range(0, 2);
            end else if (bus_valid) begin
                if (lat == 0) begin
                    bus_done  = 1'b1;
                    bus_rdata = data_of(bus_addr);
                    if (log_n < 8) begin
                        log_a[log_n] = bus_addr;
                        log_w[log_n] = bus_write;
                        log_d[log_n] = bus_wdata;
                    end
                    log_n++;
                end else begin
                    lat--;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rsp_valid) begin
            rsp_n++;
            rsp_seen = rsp_rdata;
        end
    end

    task automatic push_exp(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        exp_a[exp_n] = a;
        exp_w[exp_n] = w;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_exp(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        logic [AW-1:0] off;
        logic [AW-1:0] pre;
        bit wrap;
        exp_n = 0;
        off = a - base_addr;
        wrap = rev_affected && (off < 40'h45000);
        if (wrap) begin
            if (off == 40'h0 || off == 40'h80)        pre = 40'hC0;
            else if (off == 40'h148 || off == 40'h200) pre = 40'h28;
            else                                        pre = 40'h158;
            push_exp(base_addr + pre, 1'b0, '0);
        end
        push_exp(a, w, d);
        if (wrap) begin
            if (off == 40'h100) push_exp(base_addr + 40'h38, 1'b0, '0);
            push_exp(base_addr + 40'hB050, 1'b0, '0);
        end
    endtask

    task automatic run_req(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d, input string tag);
        build_exp(a, w, d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0;
        rsp_n = 0;
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, {tag, " R10 ready low after accept"}, DW'(req_ready), 64'd0);
        while (!req_ready) begin
            @(negedge clk);
            if (!req_ready && log_n > exp_n)
                break;
        end
        check(log_n == exp_n, {tag, " R10 access count at ready"}, DW'(log_n), DW'(exp_n));
        @(negedge clk);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check(log_a[i] == exp_a[i], {tag, " R8 access address"}, DW'(log_a[i]), DW'(exp_a[i]));
            check(log_w[i] == exp_w[i], {tag, " R9 access direction"}, DW'(log_w[i]), DW'(exp_w[i]));
            if (exp_w[i])
                check(log_d[i] == exp_d[i], {tag, " R2 write data"}, log_d[i], exp_d[i]);
        end
        if (!w) begin
            check(rsp_n == 1, {tag, " R11 one response"}, DW'(rsp_n), 64'd1);
            check(rsp_seen == data_of(a), {tag, " R11 response data"}, rsp_seen, data_of(a));
        end else begin
            check(rsp_n == 0, {tag, " R11 no response on write"}, DW'(rsp_n), 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !bus_valid && !rsp_valid, "R1 reset idle",
              DW'({req_ready, bus_valid, rsp_valid}), 64'b100);

        base_addr = 40'h00_1230_0000;
        rev_affected = 1'b0;
        run_req(base_addr,             1'b0, '0, "R2 plain read");
        run_req(base_addr + 40'h100,   1'b1, 64'hDEAD_0001_BEEF_0002, "R2 plain write");

        rev_affected = 1'b1;
        run_req(base_addr,             1'b0, '0, "R4 offset 0");
        run_req(base_addr + 40'h80,    1'b1, 64'h1111_2222_3333_4444, "R4 offset 80");
        run_req(base_addr + 40'h148,   1'b0, '0, "R5 offset 148");
        run_req(base_addr + 40'h200,   1'b1, 64'h5555_6666_7777_8888, "R5 offset 200");
        run_req(base_addr + 40'h8,     1'b0, '0, "R6 offset 8");
        run_req(base_addr + 40'h44FF8, 1'b0, '0, "R6 last offset below limit");
        run_req(base_addr + 40'h100,   1'b0, '0, "R7 offset 100 read");
        run_req(base_addr + 40'h100,   1'b1, 64'h0BAD_F00D_0000_0001, "R7 offset 100 write");
        run_req(base_addr + 40'h45000, 1'b0, '0, "R3 offset at limit");
        run_req(base_addr - 40'h8,     1'b1, 64'h9999_AAAA_BBBB_CCCC, "R3 below base");

        for (int n = 0; n < 80; n++) begin
            logic [AW-1:0] off;
            int k;
            k = $urandom_range(0, 7);
            case (k)
                0: off = 40'h0;
                1: off = 40'h80;
                2: off = 40'h100;
                3: off = 40'h148;
                4: off = 40'h200;
                5: off = AW'($urandom_range(0, 32'h44FFF)) & ~40'h7;
                6: off = 40'h45000;
                default: off = 40'h45000 + AW'($urandom_range(0, 32'hFFFFF));
            endcase
            base_addr = {AW'($urandom_range(0, 32'hFFFF)), 20'h0};
            rev_affected = 1'($urandom_range(0, 1));
            run_req(base_addr + off, 1'($urandom_range(0, 1)),
                    {32'($urandom), 32'($urandom)}, "R6 R8 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule